// File: doc/BRIEF.md
# Serial Peripheral Slave Channel

This block is the target side of a serial peripheral link with one working channel. An external master drives the serial clock and picks the device with one of four enable inputs. The block shifts words of 4 to 32 bits, most significant bit first, in any of the four clock polarity and phase modes. It takes the outgoing word from a transmit holding register and places each completed incoming word in a receive holding register. Consecutive words can run with no idle clock between them.

A host programs the channel through a simple register port. Writes take effect at the clock edge where `host_we` is high. Reads return data in the same cycle through combinational logic. Every access completes in the cycle it is presented, so there is no back-pressure on this port. The serial inputs are brought into the system clock domain through a synchroniser before any edge is detected. The system clock must run at least four times faster than the serial clock. Status flags, interrupt flags and DMA request levels tell the host when to refill the transmit side and when to empty the receive side.

The address is split into a channel field, `host_addr[4:3]`, and a register index, `host_addr[2:0]`. The register indices are: 0 control (bit 0 = channel enable), 1 configuration, 2 status, 3 transmit data, 4 receive data. The status register holds bit 0 transmit-empty, bit 1 receive-full and bit 2 overrun.

Top module: `spi_slv_chan`

## Requirements
- R1: After reset the following hold. The channel enable reads 0. Status reads 1 (transmit-empty set, receive-full and overrun clear). Configuration reads 7. No data line is driven.
- R2: Only channel 0 is implemented. A write whose channel field is 1, 2 or 3 changes nothing. A read with such a channel field returns zero.
- R3: Configuration writes are accepted only while the channel enable is 0. A write made while the channel is enabled leaves the configuration unchanged.
- R4: The configuration register has these fields:
  - bits 4:0 hold the word length minus one.
  - bit 5 is clock polarity and bit 6 is clock phase.
  - With phase 0, input data is sampled on the leading clock edge. With phase 1, it is sampled on the trailing edge.
  - Words are shifted most significant bit first.
- R5: Configuration bits 8:7 pick which of the four enable inputs selects the slave. Bit 9 gives its active level (1 = active high). While the slave is not selected, it neither drives a line nor receives data.
- R6: Each time the slave becomes selected, and at each word boundary while it stays selected, the transmit holding register is copied into the shifter. This happens even if the host has not rewritten it. The copy sets transmit-empty, and a host write to transmit data clears it.
- R7: A completed word sets receive-full, and a receive-data read clears it. If a word completes while receive-full is still set, the new word replaces the old one and overrun is set. Writing 1 to status bit 2 clears overrun.
- R8: Two words can be transferred back to back with no idle clock between them. Each word returns its own transmit word.
- R9: When configuration bit 16 is 1, no chip select is needed: the slave counts as selected whenever the channel is enabled.
- R10: Configuration bit 12 selects single-line mode and bit 13 selects a line.
  - In two-line mode, the line named by bit 13 is received and the other line is driven.
  - In single-line mode, the named line is driven in transmit-only mode and received otherwise.
  - At most one line is ever driven.
- R11: Configuration bits 11:10 set the transfer mode: 0 transmit and receive, 1 receive only, 2 transmit only.
  - In receive-only mode nothing is driven and transmit-empty does not change.
  - In transmit-only mode receive-full does not change.
- R12: The DMA read request is high while receive-full and configuration bit 14 are both set. The DMA write request is high while transmit-empty, configuration bit 15 and the channel enable are all set. The receive-full and overrun interrupt flags follow their status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe (a receive-data read pops the word) |
| host_addr | input | 5 | Channel field [4:3], register index [2:0] |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_sel | input | 4 | Four candidate slave enable inputs |
| spi_sdi | input | 2 | Data line input values |
| spi_sdo | output | 2 | Data line output values |
| spi_sdo_oe | output | 2 | Per-line output enable |
| dma_rd_req | output | 1 | Request to empty receive data |
| dma_wr_req | output | 1 | Request to fill transmit data |
| irq_tx_empty | output | 1 | Transmit-empty flag while enabled |
| irq_rx_full | output | 1 | Receive-full flag |
| irq_overrun | output | 1 | Overrun flag |

## Verification
The assertions assume that the configuration changes only through the host port. They also assume that serial input changes are far enough apart for the synchroniser to show each clock edge as its own event. The stimulus holds each serial clock level for eight system cycles. It changes data lines half a serial period ahead of the edge that samples them, and it moves the chip select only while the clock is idle. Every configuration is written with the channel disabled, except in the one case that checks that such a write is refused.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
package spi_slv_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LEN_W     = $clog2(DATA_W);
  localparam int unsigned NUM_SEL   = 4;
  localparam int unsigned SEL_W     = $clog2(NUM_SEL);
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned IDX_W     = 3;

  typedef enum logic [1:0] {
    TRM_BOTH = 2'd0,
    TRM_RX   = 2'd1,
    TRM_TX   = 2'd2,
    TRM_RSVD = 2'd3
  } trm_e;

  typedef struct packed {
    logic             no_cs;
    logic             dma_wr;
    logic             dma_rd;
    logic             rx_line;
    logic             single;
    trm_e             trm;
    logic             en_pol;
    logic [SEL_W-1:0] en_sel;
    logic             cpha;
    logic             cpol;
    logic [LEN_W-1:0] wlen;
  } conf_t;

  localparam int unsigned CONF_W = $bits(conf_t);
  localparam logic [CONF_W-1:0] CONF_RST = CONF_W'(7);

  localparam logic [IDX_W-1:0] REG_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] REG_CONF = 3'd1;
  localparam logic [IDX_W-1:0] REG_STAT = 3'd2;
  localparam logic [IDX_W-1:0] REG_TXD  = 3'd3;
  localparam logic [IDX_W-1:0] REG_RXD  = 3'd4;
endpackage

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
module spi_slv_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_regs.sv
`timescale 1ns/1ps
module spi_slv_regs
  import spi_slv_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              tx_load,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              ch_en,
  output conf_t             conf_q,
  output logic [DATA_W-1:0] tx_hold,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              ovr
);
  localparam int unsigned CH_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic              ch0, wr, rd;
  logic [DATA_W-1:0] rx_hold;

  assign idx = host_addr[IDX_W-1:0];
  assign ch0 = (host_addr[ADDR_W-1:IDX_W] == CH_W'(0));
  assign wr  = host_we & ch0;
  assign rd  = host_re & ch0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_en  <= 1'b0;
      conf_q <= conf_t'(CONF_RST);
    end else begin
      if (wr && idx == REG_CTRL) ch_en <= host_wdata[0];
      if (wr && idx == REG_CONF && !ch_en) conf_q <= conf_t'(host_wdata[CONF_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold  <= '0;
      tx_empty <= 1'b1;
    end else begin
      if (tx_load) tx_empty <= 1'b1;
      if (wr && idx == REG_TXD) begin
        tx_hold  <= host_wdata;
        tx_empty <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (rd && idx == REG_RXD) rx_full <= 1'b0;
      if (wr && idx == REG_STAT && host_wdata[2]) ovr <= 1'b0;
      if (rx_done) begin
        rx_hold <= rx_word;
        rx_full <= 1'b1;
        if (rx_full) ovr <= 1'b1;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (ch0) begin
      case (idx)
        REG_CTRL: host_rdata = DATA_W'(ch_en);
        REG_CONF: host_rdata = DATA_W'(conf_q);
        REG_STAT: host_rdata = DATA_W'({ovr, rx_full, tx_empty});
        REG_TXD:  host_rdata = tx_hold;
        REG_RXD:  host_rdata = rx_hold;
        default:  host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_slv_shift.sv
`timescale 1ns/1ps
module spi_slv_shift
  import spi_slv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  conf_t                conf,
  input  logic                 ch_en,
  input  logic [DATA_W-1:0]    tx_hold,
  input  logic                 sclk_s,
  input  logic [NUM_SEL-1:0]   sel_s,
  input  logic [NUM_LINES-1:0] sdi_s,
  output logic                 tx_load,
  output logic                 rx_done,
  output logic [DATA_W-1:0]    rx_word,
  output logic [NUM_LINES-1:0] sdo,
  output logic [NUM_LINES-1:0] sdo_oe
);
  logic              selected, sel_q, start;
  logic              sclk_q, rise, fall, lead, trail, samp_e, shft_e;
  logic              rx_en, tx_en, in_bit, out_bit, out_line, last;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, len_mask;
  logic [LEN_W-1:0]  bitcnt;
  logic              skip, pend;

  assign selected = ch_en & (conf.no_cs | (sel_s[conf.en_sel] == conf.en_pol));
  assign start    = selected & ~sel_q;
  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign lead     = conf.cpol ? fall : rise;
  assign trail    = conf.cpol ? rise : fall;
  assign samp_e   = selected & ~start & (conf.cpha ? trail : lead);
  assign shft_e   = selected & ~start & (conf.cpha ? lead : trail);
  assign last     = (bitcnt == conf.wlen);

  assign rx_en    = (conf.trm != TRM_TX);
  assign tx_en    = conf.single ? (conf.trm == TRM_TX) : (conf.trm != TRM_RX);
  assign in_bit   = sdi_s[conf.rx_line];
  assign out_line = conf.single ? conf.rx_line : ~conf.rx_line;
  assign out_bit  = tx_sh[conf.wlen];

  assign len_mask = {DATA_W{1'b1}} >> (LEN_W'(DATA_W - 1) - conf.wlen);
  assign rx_next  = {rx_sh[DATA_W-2:0], in_bit};
  assign rx_word  = rx_next & len_mask;
  assign rx_done  = samp_e & last & rx_en;
  assign tx_load  = tx_en & (start | (samp_e & last & conf.cpha) | (shft_e & pend));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= selected;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      bitcnt <= '0;
      skip   <= 1'b0;
      pend   <= 1'b0;
    end else if (!selected) begin
      bitcnt <= '0;
      skip   <= 1'b0;
      pend   <= 1'b0;
    end else if (start) begin
      tx_sh  <= tx_hold;
      bitcnt <= '0;
      skip   <= conf.cpha;
      pend   <= 1'b0;
    end else begin
      if (samp_e) begin
        rx_sh <= rx_next;
        if (last) begin
          bitcnt <= '0;
          if (conf.cpha) begin
            tx_sh <= tx_hold;
            skip  <= 1'b1;
          end else begin
            pend  <= 1'b1;
          end
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
      if (shft_e) begin
        if (pend) begin
          tx_sh <= tx_hold;
          pend  <= 1'b0;
        end else if (skip) begin
          skip  <= 1'b0;
        end else begin
          tx_sh <= tx_sh << 1;
        end
      end
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign sdo_oe[l] = selected & tx_en & (out_line == 1'(l));
    assign sdo[l]    = sdo_oe[l] & out_bit;
  end
endmodule

// File: rtl/spi_slv_chan.sv
`timescale 1ns/1ps
module spi_slv_chan
  import spi_slv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic                 host_re,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  input  logic                 spi_sclk,
  input  logic [NUM_SEL-1:0]   spi_sel,
  input  logic [NUM_LINES-1:0] spi_sdi,
  output logic [NUM_LINES-1:0] spi_sdo,
  output logic [NUM_LINES-1:0] spi_sdo_oe,
  output logic                 dma_rd_req,
  output logic                 dma_wr_req,
  output logic                 irq_tx_empty,
  output logic                 irq_rx_full,
  output logic                 irq_overrun
);
  localparam int unsigned SYN_W = 1 + NUM_SEL + NUM_LINES;

  logic                 ch_en, tx_empty, rx_full, ovr, tx_load, rx_done;
  conf_t                conf_q;
  logic [DATA_W-1:0]    tx_hold, rx_word;
  logic [SYN_W-1:0]     syn_q;
  logic                 sclk_s;
  logic [NUM_SEL-1:0]   sel_s;
  logic [NUM_LINES-1:0] sdi_s;

  spi_slv_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_sel, spi_sdi}),
    .q(syn_q)
  );
  assign {sclk_s, sel_s, sdi_s} = syn_q;

  spi_slv_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_load(tx_load), .rx_done(rx_done), .rx_word(rx_word),
    .ch_en(ch_en), .conf_q(conf_q), .tx_hold(tx_hold),
    .tx_empty(tx_empty), .rx_full(rx_full), .ovr(ovr)
  );

  spi_slv_shift shift_i (
    .clk(clk), .rst_n(rst_n),
    .conf(conf_q), .ch_en(ch_en), .tx_hold(tx_hold),
    .sclk_s(sclk_s), .sel_s(sel_s), .sdi_s(sdi_s),
    .tx_load(tx_load), .rx_done(rx_done), .rx_word(rx_word),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe)
  );

  assign dma_rd_req   = rx_full & conf_q.dma_rd;
  assign dma_wr_req   = ch_en & tx_empty & conf_q.dma_wr;
  assign irq_tx_empty = ch_en & tx_empty;
  assign irq_rx_full  = rx_full;
  assign irq_overrun  = ovr;
endmodule

// File: rtl/spi_slv_chan_chk.sv
`timescale 1ns/1ps
module spi_slv_chan_chk
  import spi_slv_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ch_en,
  input conf_t                conf,
  input logic                 host_re,
  input logic [ADDR_W-1:0]    host_addr,
  input logic                 rx_full,
  input logic                 ovr,
  input logic                 tx_empty,
  input logic [NUM_LINES-1:0] sdo_oe,
  input logic                 dma_wr_req
);
  assert_conf_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en && $past(ch_en)) |-> $stable(conf));

  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> (sdo_oe == '0));

  assert_rxfull_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(host_re && host_addr == ADDR_W'(REG_RXD)));

  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_full));

  assert_one_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sdo_oe));

  assert_rxonly_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conf.trm == TRM_RX) |-> (sdo_oe == '0));

  assert_dma_wr_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_req |-> tx_empty);
endmodule

bind spi_slv_chan spi_slv_chan_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .conf(conf_q),
  .host_re(host_re), .host_addr(host_addr), .rx_full(rx_full),
  .ovr(ovr), .tx_empty(tx_empty), .sdo_oe(spi_sdo_oe), .dma_wr_req(dma_wr_req)
);

// File: tb/spi_slv_chan_tb_top.sv
`timescale 1ns/1ps
module spi_slv_chan_tb_top;
  localparam int H = 8;
  localparam logic [2:0] CTRL = 0, CONF = 1, STAT = 2, TXR = 3, RXR = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_we = 0, host_re = 0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        spi_sclk = 0;
  logic [3:0]  spi_sel = 4'hF;
  logic [1:0]  spi_sdi = '0, spi_sdo, spi_sdo_oe;
  logic        dma_rd_req, dma_wr_req, irq_tx_empty, irq_rx_full, irq_overrun;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  spi_slv_chan dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .spi_sclk(spi_sclk), .spi_sel(spi_sel), .spi_sdi(spi_sdi),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .dma_rd_req(dma_rd_req), .dma_wr_req(dma_wr_req),
    .irq_tx_empty(irq_tx_empty), .irq_rx_full(irq_rx_full), .irq_overrun(irq_overrun)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] A(input int ch, input logic [2:0] r);
    return {2'(ch), r};
  endfunction

  function automatic logic [31:0] msk(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic logic [31:0] mkc(input int wl, input bit cpol, input bit cpha, input int sel,
                                      input bit pol, input int trm, input bit single, input bit rxl,
                                      input bit dr, input bit dw, input bit nocs);
    return (32'(nocs) << 16) | (32'(dw) << 15) | (32'(dr) << 14) | (32'(rxl) << 13) |
           (32'(single) << 12) | (32'(trm) << 10) | (32'(pol) << 9) | (32'(sel) << 7) |
           (32'(cpha) << 6) | (32'(cpol) << 5) | 32'(wl - 1);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    host_re = 1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_re = 0;
  endtask

  task automatic setup(input logic [31:0] c, input bit cpol, input bit pol, input logic [31:0] tx);
    logic [31:0] dummy;
    spi_sclk = cpol; spi_sel = {4{~pol}};
    wait_cyc(6);
    wr(A(0, CTRL), 0);
    wr(A(0, STAT), 4);
    rd(A(0, RXR), dummy);
    wr(A(0, CONF), c);
    wr(A(0, TXR), tx);
    wr(A(0, CTRL), 1);
    wait_cyc(4);
  endtask

  task automatic spi_word(input logic [31:0] mo, input int len, input bit cpol, input bit cpha,
                          input int il, input int ol, output logic [31:0] mi);
    mi = '0;
    for (int b = len - 1; b >= 0; b--) begin
      if (!cpha) begin
        spi_sdi[il] = mo[b]; wait_cyc(H);
        spi_sclk = ~cpol; mi = {mi[30:0], spi_sdo[ol]}; wait_cyc(H);
        spi_sclk = cpol;
      end else begin
        spi_sclk = ~cpol; spi_sdi[il] = mo[b]; wait_cyc(H);
        spi_sclk = cpol; mi = {mi[30:0], spi_sdo[ol]}; wait_cyc(H);
      end
    end
  endtask

  task automatic run_word(input bit cpol, input bit cpha, input int s, input bit pol, input int len,
                          input logic [31:0] mo, input int il, input int ol, output logic [31:0] mi);
    spi_sel[s] = pol; wait_cyc(H);
    spi_word(mo, len, cpol, cpha, il, ol, mi);
    wait_cyc(H);
    spi_sel[s] = ~pol; wait_cyc(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, mi, mi2, c, tx, mo;
    int lens[4] = '{4, 8, 13, 32};
    int k = 0;
    wait_cyc(5); rst_n = 1; wait_cyc(3);

    // R1 reset state
    rd(A(0, CTRL), v); chk("R1 ctrl", v, 0);
    rd(A(0, STAT), v); chk("R1 stat", v, 1);
    rd(A(0, CONF), v); chk("R1 conf", v, 7);
    chk("R1 oe", 32'(spi_sdo_oe), 0);

    // R2 other channels ignored
    wr(A(1, CTRL), 1); rd(A(0, CTRL), v); chk("R2 ch1 enable ignored", v, 0);
    wr(A(2, TXR), 32'h55); rd(A(0, STAT), v); chk("R2 ch2 tx ignored", v, 1);
    wr(A(3, CONF), 32'h1F); rd(A(0, CONF), v); chk("R2 ch3 conf ignored", v, 7);
    rd(A(1, CONF), v); chk("R2 ch1 read zero", v, 0);

    // R4 R5 sweep: modes x lengths x select pins / polarity
    for (int m = 0; m < 4; m++)
      for (int li = 0; li < 4; li++)
        for (int s = 0; s < 4; s++) begin
          automatic int len = lens[li];
          automatic bit cpol = m[1];
          automatic bit cpha = m[0];
          automatic bit pol = s[0];
          k++;
          tx = (32'hA5C3_96E1 ^ (32'(k) * 32'h1F3D_5B79)) & msk(len);
          mo = (32'h3C69_D21B + (32'(k) * 32'h0B5A_7E93)) & msk(len);
          setup(mkc(len, cpol, cpha, s, pol, 0, 0, 0, 0, 0, 0), cpol, pol, tx);
          run_word(cpol, cpha, s, pol, len, mo, 0, 1, mi);
          chk("R4 R5 slave-out word", mi, tx);
          rd(A(0, RXR), v); chk("R4 R5 slave-in word", v, mo);
        end

    // R3 configuration frozen while enabled
    c = mkc(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    setup(c, 0, 0, 32'h11);
    wr(A(0, CONF), mkc(16, 1, 1, 2, 1, 0, 0, 0, 0, 0, 0));
    rd(A(0, CONF), v); chk("R3 conf write refused", v, c);

    // R6 stale reload, R7 overrun
    setup(mkc(8, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0), 0, 0, 32'hC7);
    rd(A(0, STAT), v); chk("R6 tx written clears empty", v & 1, 0);
    run_word(0, 1, 1, 0, 8, 32'h21, 0, 1, mi);
    chk("R6 first word", mi, 32'hC7);
    rd(A(0, STAT), v); chk("R6 R7 stat after word", v, 3);
    run_word(0, 1, 1, 0, 8, 32'h84, 0, 1, mi);
    chk("R6 stale word resent", mi, 32'hC7);
    rd(A(0, STAT), v); chk("R7 overrun stat", v, 7);
    chk("R7 irq overrun", 32'(irq_overrun), 1);
    wr(A(0, STAT), 4); rd(A(0, STAT), v); chk("R7 overrun cleared", v, 3);
    rd(A(0, RXR), v); chk("R7 newer word kept", v, 32'h84);
    rd(A(0, STAT), v); chk("R7 read pops", v, 1);

    // R8 back to back, modes 0 and 3
    for (int m = 0; m < 4; m += 3) begin
      automatic bit cpol = m[1];
      automatic bit cpha = m[0];
      setup(mkc(8, cpol, cpha, 0, 0, 0, 0, 0, 0, 0, 0), cpol, 0, 32'h3C);
      spi_sel[0] = 0; wait_cyc(H);
      wr(A(0, TXR), 32'hD2);
      spi_word(32'h96, 8, cpol, cpha, 0, 1, mi);
      spi_word(32'h5A, 8, cpol, cpha, 0, 1, mi2);
      wait_cyc(H); spi_sel[0] = 1; wait_cyc(8);
      chk("R8 first word", mi, 32'h3C);
      chk("R8 second word", mi2, 32'hD2);
      rd(A(0, RXR), v); chk("R8 last received", v, 32'h5A);
    end

    // R9 no chip select needed
    setup(mkc(12, 1, 0, 3, 0, 0, 0, 0, 0, 0, 1), 1, 0, 32'hABC);
    wait_cyc(H);
    spi_word(32'h5E7, 12, 1, 0, 0, 1, mi);
    wait_cyc(8);
    chk("R9 no-select out", mi, 32'hABC);
    rd(A(0, RXR), v); chk("R9 no-select in", v, 32'h5E7);

    // R5 wrong pin does not select
    setup(mkc(8, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0), 0, 0, 32'h77);
    spi_sel[1] = 0; wait_cyc(H);
    chk("R5 unselected no drive", 32'(spi_sdo_oe), 0);
    spi_word(32'hFF, 8, 0, 0, 0, 1, mi);
    spi_sel[1] = 1; wait_cyc(8);
    rd(A(0, STAT), v); chk("R5 unselected no receive", v, 0);

    // R10 line assignments
    setup(mkc(8, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0), 0, 0, 32'h6B);
    run_word(0, 0, 0, 0, 8, 32'h1D, 1, 0, mi);
    chk("R10 swapped out", mi, 32'h6B);
    rd(A(0, RXR), v); chk("R10 swapped in", v, 32'h1D);
    setup(mkc(8, 0, 0, 0, 0, 2, 1, 1, 0, 0, 0), 0, 0, 32'hB4);
    spi_sel[0] = 0; wait_cyc(H);
    chk("R10 single-line drive", 32'(spi_sdo_oe), 2);
    spi_word(32'h00, 8, 0, 0, 0, 1, mi);
    wait_cyc(H); spi_sel[0] = 1; wait_cyc(8);
    chk("R10 single-line out", mi, 32'hB4);
    setup(mkc(8, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0), 0, 0, 32'h00);
    spi_sel[0] = 0; wait_cyc(H);
    chk("R10 single-line receive no drive", 32'(spi_sdo_oe), 0);
    spi_word(32'hC9, 8, 0, 0, 0, 1, mi);
    wait_cyc(H); spi_sel[0] = 1; wait_cyc(8);
    rd(A(0, RXR), v); chk("R10 single-line in", v, 32'hC9);

    // R11 transfer modes
    setup(mkc(8, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0), 0, 0, 32'h99);
    spi_sel[0] = 0; wait_cyc(H);
    chk("R11 rx-only no drive", 32'(spi_sdo_oe), 0);
    spi_word(32'h3A, 8, 0, 0, 0, 1, mi);
    wait_cyc(H); spi_sel[0] = 1; wait_cyc(8);
    rd(A(0, STAT), v); chk("R11 rx-only keeps tx", v, 2);
    rd(A(0, RXR), v); chk("R11 rx-only data", v, 32'h3A);
    setup(mkc(8, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0), 0, 0, 32'hE1);
    run_word(0, 0, 0, 0, 8, 32'h44, 0, 1, mi);
    chk("R11 tx-only out", mi, 32'hE1);
    rd(A(0, STAT), v); chk("R11 tx-only no receive", v, 1);

    // R12 DMA requests and flags
    setup(mkc(8, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0), 0, 0, 32'h12);
    chk("R12 wr req low when filled", 32'(dma_wr_req), 0);
    spi_sel[0] = 0; wait_cyc(H);
    chk("R12 wr req after load", 32'(dma_wr_req), 1);
    spi_word(32'h34, 8, 0, 0, 0, 1, mi);
    wait_cyc(H); spi_sel[0] = 1; wait_cyc(8);
    chk("R12 rd req when full", 32'(dma_rd_req), 1);
    chk("R12 irq rx full", 32'(irq_rx_full), 1);
    rd(A(0, RXR), v);
    chk("R12 rd req after pop", 32'(dma_rd_req), 0);
    setup(mkc(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0, 0, 32'h12);
    run_word(0, 0, 0, 0, 8, 32'h56, 0, 1, mi);
    chk("R12 rd req gated off", 32'(dma_rd_req), 0);
    chk("R12 wr req gated off", 32'(dma_wr_req), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule